// File: doc/BRIEF.md
# Settable 24-Hour Time-of-Day Clock

This block keeps the time of day as six BCD digits (hours, minutes, seconds) in 24-hour form. A two-stage prescaler turns the system clock into a 250 µs base tick and then into a once-per-second pulse. The running counters cascade from seconds to minutes to hours, and the time returns to midnight after the last second of the day.

Four raw push-button inputs are synchronized and debounced. Each press becomes one single-cycle event. The events drive a small edit machine. A select key walks through the hour, minute and second fields. Up and down keys step the chosen field within its own range. A confirm key leaves edit mode. The clock never stops while a field is edited, and the prescaler never restarts.

A scan multiplexer drives one of six common-cathode style digits at a time, left to right, in the form HH.MM.SS. The digits of the field being edited blink at about 2 Hz.

Top module: `tod_clock_top`

## Requirements
- R1: While reset is asserted and directly after it is released, `time_bcd` is 0, `edit_field` is 0 and `digit_en_n` is 6'b111110, with only the leftmost digit enabled.
- R2: `time_bcd` is {hour tens, hour ones, minute tens, minute ones, second tens, second ones}, each digit a 4-bit BCD value. Seconds advance once every TICK_DIV*TICKS_PER_SEC clocks. Seconds run 00..59 and wrap to 00, carrying one into minutes. Minutes carry into hours in the same way.
- R3: The second after 23:59:59 gives 00:00:00.
- R4: `edit_field` encodes 0 = running, 1 = hours, 2 = minutes, 3 = seconds. A select event moves 0→1→2→3→1. A confirm event returns the field to 0, and confirm wins over select when both arrive in the same cycle.
- R5: In edit mode an up event adds one to the chosen field and a down event subtracts one. The field wraps within its own range (hours 00..23, minutes and seconds 00..59), and the step never changes a neighbouring field.
- R6: Up and down events have no effect on the time while `edit_field` is 0.
- R7: Key activity never shifts the cadence of second updates. Every natural seconds change stays on the same TICK_DIV*TICKS_PER_SEC grid as before the edit.
- R8: When an edit step and a natural carry land on the selected field in the same cycle, the field takes the edited value. All other fields take their natural next value.
- R9: A key level is accepted only after it has been stable for DEBOUNCE_TICKS base ticks. A press yields exactly one event however long it is held. A release, a one-cycle glitch or a bouncing edge yields none.
- R10: Exactly one bit of `digit_en_n` is low at any time. Bit i is digit position i counted from the left. The enabled position advances by one, wrapping 5→0, every SCAN_TICKS base ticks.
- R11: `seg` carries segments a..g on bits 0..6, active high, with the usual codes (0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F) for the digit at the enabled position, one cycle after that digit's value. `seg_dp` is high only at positions 1 and 3.
- R12: In edit mode the two digits of the chosen field are blanked (`seg` = 0) in alternate BLINK_TICKS-tick phases. Other digits are never blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_select | input | 1 | Raw select key, high when pressed |
| key_up | input | 1 | Raw up key, high when pressed |
| key_down | input | 1 | Raw down key, high when pressed |
| key_confirm | input | 1 | Raw confirm key, high when pressed |
| time_bcd | output | 24 | Current time, six BCD digits HH MM SS |
| edit_field | output | 2 | Field being edited (0 none, 1 h, 2 m, 3 s) |
| seg | output | 7 | Segment lines a..g, active high |
| seg_dp | output | 1 | Decimal point for the enabled digit |
| digit_en_n | output | 6 | Active-low digit enables, bit 0 leftmost |

## Verification
The natural seconds-to-minutes carry and a down step on the minutes field can land in the same clock. The bench provokes this by holding the minutes field in edit mode. It waits for the first cycle of second 59 and then starts a down press at each of ten successive clock offsets, which sweeps the debounced event across the carry cycle. At each offset the bench watches the wrap cycle. When the minutes show the decremented value at the wrap, the edit won the collision and the final minutes must equal that value. Otherwise carry and step both apply and the minutes must end unchanged. At least one offset must produce the collision.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int NUM_KEYS   = 4;
    localparam int NUM_DIGITS = 6;
    localparam int TIME_W     = 4 * NUM_DIGITS;

    localparam int KEY_SEL = 0;
    localparam int KEY_UP  = 1;
    localparam int KEY_DN  = 2;
    localparam int KEY_OK  = 3;

    localparam logic [7:0] HOUR_TOP = 8'h23;
    localparam logic [7:0] SIXTY_TOP = 8'h59;

    typedef enum logic [1:0] {
        FLD_NONE = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_MIN  = 2'd2,
        FLD_SEC  = 2'd3
    } fld_e;

    // one BCD pair up, wrapping at top
    function automatic logic [7:0] bcd_step_up(input logic [7:0] v, input logic [7:0] top);
        if (v == top)
            return 8'h00;
        else if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // one BCD pair down, wrapping to top
    function automatic logic [7:0] bcd_step_dn(input logic [7:0] v, input logic [7:0] top);
        if (v == 8'h00)
            return top;
        else if (v[3:0] == 4'd0)
            return {v[7:4] - 4'd1, 4'd9};
        else
            return {v[7:4], v[3:0] - 4'd1};
    endfunction

    // segments g..a on bits 6..0
    function automatic logic [6:0] seg_code(input logic [3:0] v);
        case (v)
            4'd0:    return 7'h3F;
            4'd1:    return 7'h06;
            4'd2:    return 7'h5B;
            4'd3:    return 7'h4F;
            4'd4:    return 7'h66;
            4'd5:    return 7'h6D;
            4'd6:    return 7'h7D;
            4'd7:    return 7'h07;
            4'd8:    return 7'h7F;
            4'd9:    return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICK_DIV      = 3000,
    parameter int TICKS_PER_SEC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic sec_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
    localparam logic [SW-1:0] SEC_LAST = SW'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [SW-1:0] tcnt;
        logic          tick;
        logic          sec;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d      = pre_q;
        pre_d.tick = 1'b0;
        pre_d.sec  = 1'b0;
        if (pre_q.div == DIV_LAST) begin
            pre_d.div  = '0;
            pre_d.tick = 1'b1;
        end else begin
            pre_d.div = pre_q.div + 1'b1;
        end
        if (pre_q.tick) begin
            if (pre_q.tcnt == SEC_LAST) begin
                pre_d.tcnt = '0;
                pre_d.sec  = 1'b1;
            end else begin
                pre_d.tcnt = pre_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = pre_q.tick;
    assign sec_o  = pre_q.sec;
endmodule

// File: rtl/tod_key_cond.sv
module tod_key_cond #(
    parameter int DEBOUNCE_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic press_o
);
    localparam int CW = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_TICKS - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          stable;
        logic [CW-1:0] cnt;
        logic          press;
    } kc_t;

    kc_t kc_d, kc_q;

    always_comb begin
        kc_d       = kc_q;
        kc_d.s1    = raw_i;
        kc_d.s2    = kc_q.s1;
        kc_d.press = 1'b0;
        if (kc_q.s2 == kc_q.stable) begin
            kc_d.cnt = '0;
        end else if (tick_i) begin
            if (kc_q.cnt == CNT_LAST) begin
                kc_d.cnt    = '0;
                kc_d.stable = kc_q.s2;
                kc_d.press  = kc_q.s2;
            end else begin
                kc_d.cnt = kc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kc_q <= '0;
        else        kc_q <= kc_d;
    end

    assign press_o = kc_q.press;
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
    import tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_i,
    input  logic [NUM_KEYS-1:0] key_i,
    output logic [TIME_W-1:0]   time_o,
    output fld_e                field_o
);
    typedef struct packed {
        fld_e       fld;
        logic [7:0] hh;
        logic [7:0] mm;
        logic [7:0] ss;
    } core_t;

    core_t core_d, core_q;
    logic  step_up, step_dn;

    always_comb begin
        core_d  = core_q;
        step_up = key_i[KEY_UP];
        step_dn = key_i[KEY_DN] & ~key_i[KEY_UP];

        // natural cascade
        if (sec_i) begin
            if (core_q.ss == SIXTY_TOP) begin
                core_d.ss = 8'h00;
                if (core_q.mm == SIXTY_TOP) begin
                    core_d.mm = 8'h00;
                    core_d.hh = bcd_step_up(core_q.hh, HOUR_TOP);
                end else begin
                    core_d.mm = bcd_step_up(core_q.mm, SIXTY_TOP);
                end
            end else begin
                core_d.ss = bcd_step_up(core_q.ss, SIXTY_TOP);
            end
        end

        // edit step overrides only the chosen field
        if (step_up || step_dn) begin
            case (core_q.fld)
                FLD_HOUR: core_d.hh = step_up ? bcd_step_up(core_q.hh, HOUR_TOP)
                                              : bcd_step_dn(core_q.hh, HOUR_TOP);
                FLD_MIN:  core_d.mm = step_up ? bcd_step_up(core_q.mm, SIXTY_TOP)
                                              : bcd_step_dn(core_q.mm, SIXTY_TOP);
                FLD_SEC:  core_d.ss = step_up ? bcd_step_up(core_q.ss, SIXTY_TOP)
                                              : bcd_step_dn(core_q.ss, SIXTY_TOP);
                default:  ;
            endcase
        end

        // field selection
        if (key_i[KEY_OK]) begin
            core_d.fld = FLD_NONE;
        end else if (key_i[KEY_SEL]) begin
            case (core_q.fld)
                FLD_NONE: core_d.fld = FLD_HOUR;
                FLD_HOUR: core_d.fld = FLD_MIN;
                FLD_MIN:  core_d.fld = FLD_SEC;
                default:  core_d.fld = FLD_HOUR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{fld: FLD_NONE, hh: 8'h00, mm: 8'h00, ss: 8'h00};
        else        core_q <= core_d;
    end

    assign time_o  = {core_q.hh, core_q.mm, core_q.ss};
    assign field_o = core_q.fld;
endmodule

// File: rtl/tod_scan_mux.sv
module tod_scan_mux
    import tod_pkg::*;
#(
    parameter int SCAN_TICKS  = 4,
    parameter int BLINK_TICKS = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [TIME_W-1:0]     time_i,
    input  fld_e                  field_i,
    output logic [6:0]            seg_o,
    output logic                  dp_o,
    output logic [NUM_DIGITS-1:0] dig_n_o
);
    localparam int SCW = (SCAN_TICKS > 1) ? $clog2(SCAN_TICKS) : 1;
    localparam int BCW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam int IW  = $clog2(NUM_DIGITS);
    localparam logic [SCW-1:0] SCAN_LAST  = SCW'(SCAN_TICKS - 1);
    localparam logic [BCW-1:0] BLINK_LAST = BCW'(BLINK_TICKS - 1);
    localparam logic [IW-1:0]  IDX_LAST   = IW'(NUM_DIGITS - 1);

    typedef struct packed {
        logic [SCW-1:0]        scnt;
        logic [IW-1:0]         idx;
        logic [BCW-1:0]        bcnt;
        logic                  blink_off;
        logic [6:0]            seg;
        logic                  dp;
        logic [NUM_DIGITS-1:0] dig_n;
    } sm_t;

    sm_t        sm_d, sm_q;
    logic [3:0] digit;
    logic [1:0] pos_fld;
    logic       blank;

    always_comb begin
        sm_d = sm_q;
        if (tick_i) begin
            if (sm_q.scnt == SCAN_LAST) begin
                sm_d.scnt = '0;
                sm_d.idx  = (sm_q.idx == IDX_LAST) ? '0 : sm_q.idx + 1'b1;
            end else begin
                sm_d.scnt = sm_q.scnt + 1'b1;
            end
            if (sm_q.bcnt == BLINK_LAST) begin
                sm_d.bcnt      = '0;
                sm_d.blink_off = ~sm_q.blink_off;
            end else begin
                sm_d.bcnt = sm_q.bcnt + 1'b1;
            end
        end

        digit   = 4'(time_i >> (4 * (NUM_DIGITS - 1 - int'(sm_q.idx))));
        pos_fld = 2'(sm_q.idx >> 1) + 2'd1;
        blank   = sm_q.blink_off && (field_i != FLD_NONE) && (field_i == fld_e'(pos_fld));

        sm_d.seg   = blank ? 7'h00 : seg_code(digit);
        sm_d.dp    = (sm_q.idx == IW'(1)) || (sm_q.idx == IW'(3));
        sm_d.dig_n = ~(NUM_DIGITS'(1) << sm_q.idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sm_q       <= '0;
            sm_q.dig_n <= ~NUM_DIGITS'(1);
        end else begin
            sm_q <= sm_d;
        end
    end

    assign seg_o   = sm_q.seg;
    assign dp_o    = sm_q.dp;
    assign dig_n_o = sm_q.dig_n;
endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
    import tod_pkg::*;
#(
    parameter int TICK_DIV       = 3000,
    parameter int TICKS_PER_SEC  = 4000,
    parameter int DEBOUNCE_TICKS = 80,
    parameter int SCAN_TICKS     = 4,
    parameter int BLINK_TICKS    = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_select,
    input  logic        key_up,
    input  logic        key_down,
    input  logic        key_confirm,
    output logic [23:0] time_bcd,
    output logic [1:0]  edit_field,
    output logic [6:0]  seg,
    output logic        seg_dp,
    output logic [5:0]  digit_en_n
);
    logic                tick;
    logic                sec_pulse;
    logic [NUM_KEYS-1:0] key_raw;
    logic [NUM_KEYS-1:0] key_p;
    fld_e                field;

    assign key_raw[KEY_SEL] = key_select;
    assign key_raw[KEY_UP]  = key_up;
    assign key_raw[KEY_DN]  = key_down;
    assign key_raw[KEY_OK]  = key_confirm;

    tod_prescaler #(
        .TICK_DIV      (TICK_DIV),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick),
        .sec_o  (sec_pulse)
    );

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        tod_key_cond #(
            .DEBOUNCE_TICKS (DEBOUNCE_TICKS)
        ) u_kc (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .raw_i   (key_raw[k]),
            .press_o (key_p[k])
        );
    end

    tod_time_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_i   (sec_pulse),
        .key_i   (key_p),
        .time_o  (time_bcd),
        .field_o (field)
    );

    tod_scan_mux #(
        .SCAN_TICKS  (SCAN_TICKS),
        .BLINK_TICKS (BLINK_TICKS)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .time_i  (time_bcd),
        .field_i (field),
        .seg_o   (seg),
        .dp_o    (seg_dp),
        .dig_n_o (digit_en_n)
    );

    assign edit_field = field;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sec_pulse,
    input logic [3:0]  key_p,
    input logic [23:0] time_bcd,
    input logic [1:0]  edit_field,
    input logic [5:0]  digit_en_n
);
    // R10
    scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~digit_en_n) == 1);

    // R2
    bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_bcd[3:0] <= 4'd9 && time_bcd[7:4] <= 4'd5 &&
        time_bcd[11:8] <= 4'd9 && time_bcd[15:12] <= 4'd5 &&
        time_bcd[19:16] <= 4'd9 && time_bcd[23:16] <= 8'h23);

    // R7
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && key_p == 4'b0000) |=> $stable(time_bcd));

    // R6
    run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edit_field == 2'd0 && !sec_pulse && !key_p[0]) |=> $stable(time_bcd));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_p[0] && !key_p[3]) |=> $stable(edit_field));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_p != 4'b0000) |=> ((key_p & $past(key_p)) == 4'b0000));

    // R3
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && edit_field == 2'd0 && time_bcd == 24'h235959) |=> time_bcd == 24'h000000);
endmodule

bind tod_clock_top tod_clock_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_pulse  (sec_pulse),
    .key_p      (key_p),
    .time_bcd   (time_bcd),
    .edit_field (edit_field),
    .digit_en_n (digit_en_n)
);

// File: tb/tod_clock_top_tb_top.sv
module tod_clock_top_tb_top;
    localparam int TB_DIV   = 2;
    localparam int TB_TPS   = 5;
    localparam int TB_DEB   = 2;
    localparam int TB_SCAN  = 1;
    localparam int TB_BLINK = 4;
    localparam int SEC_CLKS  = TB_DIV * TB_TPS;
    localparam int SCAN_CLKS = TB_DIV * TB_SCAN;
    localparam int OP_SEL = 0, OP_UP = 1, OP_DN = 2, OP_OK = 3;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] fld;
        logic [7:0] hh;
        logic [7:0] mm;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{2'd1, 2'd0, 8'h00, 8'h00},
        '{2'd2, 2'd0, 8'h00, 8'h00},
        '{2'd0, 2'd1, 8'h00, 8'h00},
        '{2'd1, 2'd1, 8'h01, 8'h00},
        '{2'd2, 2'd1, 8'h00, 8'h00},
        '{2'd2, 2'd1, 8'h23, 8'h00},
        '{2'd1, 2'd1, 8'h00, 8'h00},
        '{2'd0, 2'd2, 8'h00, 8'h00},
        '{2'd2, 2'd2, 8'h00, 8'h59},
        '{2'd1, 2'd2, 8'h00, 8'h00},
        '{2'd1, 2'd2, 8'h00, 8'h01},
        '{2'd0, 2'd3, 8'h00, 8'h01},
        '{2'd0, 2'd1, 8'h00, 8'h01},
        '{2'd3, 2'd0, 8'h00, 8'h01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  keys = 4'b0000;
    logic [23:0] time_bcd;
    logic [1:0]  edit_field;
    logic [6:0]  seg;
    logic        seg_dp;
    logic [5:0]  digit_en_n;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tod_clock_top #(
        .TICK_DIV       (TB_DIV),
        .TICKS_PER_SEC  (TB_TPS),
        .DEBOUNCE_TICKS (TB_DEB),
        .SCAN_TICKS     (TB_SCAN),
        .BLINK_TICKS    (TB_BLINK)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_select  (keys[0]),
        .key_up      (keys[1]),
        .key_down    (keys[2]),
        .key_confirm (keys[3]),
        .time_bcd    (time_bcd),
        .edit_field  (edit_field),
        .seg         (seg),
        .seg_dp      (seg_dp),
        .digit_en_n  (digit_en_n)
    );

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        case (v)
            4'd0: return 7'b0111111;
            4'd1: return 7'b0000110;
            4'd2: return 7'b1011011;
            4'd3: return 7'b1001111;
            4'd4: return 7'b1100110;
            4'd5: return 7'b1101101;
            4'd6: return 7'b1111101;
            4'd7: return 7'b0000111;
            4'd8: return 7'b1111111;
            default: return 7'b1101111;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic press(input int k, input int hold = 12);
        @(negedge clk) keys[k] = 1'b1;
        repeat (hold) @(negedge clk);
        keys[k] = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic goto_field(input int f);
        press(OP_OK);
        repeat (f) press(OP_SEL);
    endtask

    // step field f toward a binary target using the shorter direction
    task automatic adjust(input int f, input int target, input int range);
        int cur;
        goto_field(f);
        for (int it = 0; it < 40; it++) begin
            cur = (f == 1) ? b2i(time_bcd[23:16]) : b2i(time_bcd[15:8]);
            if (cur == target) break;
            if (((target - cur + range) % range) <= range / 2) press(OP_UP);
            else press(OP_DN);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [23:0] prev_t;
        logic [7:0]  m0, h0, wrap_m;
        int          ref_c, edges, bad, last_pos, last_chg, pos, seg_bad, coll, lows;
        bit          seen_blank_sel, seen_lit_sel, other_blank, wrap_seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(time_bcd == 24'h0 && edit_field == 2'd0 && digit_en_n == 6'b111110,
            "R1", "state in reset", {edit_field, digit_en_n, time_bcd}, {2'd0, 6'b111110, 24'h0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(time_bcd == 24'h0 && edit_field == 2'd0 && digit_en_n == 6'b111110,
            "R1", "state after release", {edit_field, digit_en_n, time_bcd}, {2'd0, 6'b111110, 24'h0});

        // vector table: R4 selection, R5 stepping, R6 ignored in run mode
        foreach (VECS[i]) begin
            press(int'(VECS[i].op));
            if (VECS[i].op == 2'd0 || VECS[i].op == 2'd3)
                chk(edit_field == VECS[i].fld, "R4", $sformatf("row %0d field", i),
                    edit_field, VECS[i].fld);
            else if (VECS[i].fld == 2'd0)
                chk(time_bcd[23:8] == {VECS[i].hh, VECS[i].mm} && edit_field == 2'd0, "R6",
                    $sformatf("row %0d run step", i), time_bcd[23:8], {VECS[i].hh, VECS[i].mm});
            else
                chk(time_bcd[23:8] == {VECS[i].hh, VECS[i].mm} && edit_field == VECS[i].fld, "R5",
                    $sformatf("row %0d step", i), time_bcd[23:8], {VECS[i].hh, VECS[i].mm});
        end

        // R10 and R11: scan order, interval, segment and dp content in run mode
        @(negedge clk);
        prev_t = time_bcd;
        last_pos = -1; last_chg = -1; bad = 0; seg_bad = 0; lows = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if ($countones(~digit_en_n) != 1) lows++;
            pos = 0;
            for (int b = 0; b < 6; b++) if (!digit_en_n[b]) pos = b;
            if (pos != last_pos) begin
                if (last_pos >= 0 && pos != (last_pos + 1) % 6) bad++;
                if (last_chg >= 0 && cyc - last_chg != SCAN_CLKS) bad++;
                if (last_pos >= 0) last_chg = cyc;
                last_pos = pos;
            end
            if (seg != exp_seg(prev_t[4*(5-pos) +: 4]) || seg_dp != (pos == 1 || pos == 3))
                seg_bad++;
            prev_t = time_bcd;
        end
        chk(lows == 0, "R10", "one enable low", lows, 0);
        chk(bad == 0, "R10", "scan order/interval errors", bad, 0);
        chk(seg_bad == 0, "R11", "segment/dp mismatches", seg_bad, 0);

        // R12: blinking of the chosen field only
        goto_field(1);
        seen_blank_sel = 0; seen_lit_sel = 0; other_blank = 0;
        for (int n = 0; n < 80; n++) begin
            @(negedge clk);
            pos = 0;
            for (int b = 0; b < 6; b++) if (!digit_en_n[b]) pos = b;
            if (pos < 2) begin
                if (seg == 7'h00) seen_blank_sel = 1; else seen_lit_sel = 1;
            end else if (seg == 7'h00) begin
                other_blank = 1;
            end
        end
        chk(seen_blank_sel && seen_lit_sel, "R12", "hour digits blink", {seen_blank_sel, seen_lit_sel}, 2'b11);
        chk(!other_blank, "R12", "other digits never blank", other_blank, 0);

        // R9: glitch, bounce and long hold on the up key (hours in edit)
        h0 = time_bcd[23:16];
        @(negedge clk) keys[OP_UP] = 1'b1;
        @(negedge clk) keys[OP_UP] = 1'b0;
        repeat (20) @(negedge clk);
        chk(time_bcd[23:16] == h0, "R9", "one-cycle glitch ignored", time_bcd[23:16], h0);
        for (int n = 0; n < 10; n++) begin
            @(negedge clk) keys[OP_UP] = ~keys[OP_UP];
        end
        press(OP_UP, 60);
        chk(time_bcd[23:16] == i2b((b2i(h0) + 1) % 24), "R9", "bounce plus long hold gives one step",
            time_bcd[23:16], i2b((b2i(h0) + 1) % 24));

        // R7: second grid unaffected by edits
        press(OP_OK);
        prev_t = time_bcd;
        ref_c = -1;
        while (ref_c < 0) begin
            @(negedge clk);
            if (time_bcd[7:0] != prev_t[7:0]) ref_c = cyc;
            prev_t = time_bcd;
        end
        edges = 0; bad = 0;
        fork
            begin
                press(OP_SEL);
                repeat (4) press(OP_UP);
                press(OP_DN);
            end
            begin
                for (int n = 0; n < 160; n++) begin
                    @(negedge clk);
                    if (time_bcd[7:0] != prev_t[7:0]) begin
                        edges++;
                        if ((cyc - ref_c) % SEC_CLKS != 0) bad++;
                    end
                    prev_t = time_bcd;
                end
            end
        join
        chk(bad == 0 && edges >= 12, "R7", "off-grid second edges", bad, 0);

        // R2: cadence and seconds-to-minutes carry in run mode
        press(OP_OK);
        prev_t = time_bcd;
        while (!(time_bcd[7:0] == 8'h59 && prev_t[7:0] != 8'h59)) begin
            prev_t = time_bcd;
            @(negedge clk);
        end
        m0 = time_bcd[15:8];
        repeat (SEC_CLKS) @(negedge clk);
        chk(time_bcd[7:0] == 8'h00 && time_bcd[15:8] == i2b((b2i(m0) + 1) % 60), "R2",
            "59 wraps and carries", time_bcd[15:0], {i2b((b2i(m0) + 1) % 60), 8'h00});
        repeat (SEC_CLKS - 1) @(negedge clk);
        chk(time_bcd[7:0] == 8'h00, "R2", "second holds until period ends", time_bcd[7:0], 8'h00);
        @(negedge clk);
        chk(time_bcd[7:0] == 8'h01, "R2", "next second after one period", time_bcd[7:0], 8'h01);

        // R8: sweep a minute down-step across the carry cycle
        goto_field(2);
        coll = 0;
        for (int off = 0; off < 10; off++) begin
            prev_t = time_bcd;
            while (!(time_bcd[7:0] == 8'h59 && prev_t[7:0] != 8'h59)) begin
                prev_t = time_bcd;
                @(negedge clk);
            end
            m0 = time_bcd[15:8];
            wrap_m = 8'hFF;
            fork
                begin
                    repeat (off) @(negedge clk);
                    press(OP_DN);
                end
                begin
                    for (int n = 0; n < 50; n++) begin
                        @(negedge clk);
                        if (prev_t[7:0] == 8'h59 && time_bcd[7:0] == 8'h00) wrap_m = time_bcd[15:8];
                        prev_t = time_bcd;
                    end
                end
            join
            if (wrap_m == i2b((b2i(m0) + 59) % 60)) begin
                coll++;
                chk(time_bcd[15:8] == wrap_m, "R8", $sformatf("offset %0d edit wins", off),
                    time_bcd[15:8], wrap_m);
            end else begin
                chk(time_bcd[15:8] == m0, "R8", $sformatf("offset %0d carry and step", off),
                    time_bcd[15:8], m0);
            end
        end
        chk(coll >= 1, "R8", "collision reached", coll, 1);

        // R3: end-of-day wrap
        for (int a = 0; a < 4; a++) begin
            adjust(1, 23, 24);
            adjust(2, 59, 60);
            press(OP_OK);
            if (time_bcd[23:8] == 16'h2359) break;
        end
        wrap_seen = 0;
        for (int n = 0; n < 800 && !wrap_seen; n++) begin
            @(negedge clk);
            if (time_bcd == 24'h235959) wrap_seen = 1;
        end
        chk(wrap_seen, "R3", "reached 23:59:59", time_bcd, 24'h235959);
        repeat (SEC_CLKS) @(negedge clk);
        chk(time_bcd == 24'h000000, "R3", "day wrap to midnight", time_bcd, 24'h000000);

        finish_run();
    end
endmodule